// File: doc/BRIEF.md
# Phase-Switching Programmable Prescaler

This block divides a fast input clock by a programmable ratio between 16 and 31. A two-flop quadrature generator makes four copies of a quarter-rate clock, each one input cycle later than the one before. A phase-select multiplexer picks one copy. Moving the selection to the next later copy, right after the selected copy rises, stretches that quarter-rate period from 4 to 5 input cycles. Each such step therefore swallows exactly one input cycle. The multiplexer and its select register only change state on quarter-rate edges, so they run at a quarter of the input rate.

The front stage makes up to three steps per output period, which turns it into a 4/5/6/7 stage. Its output drives a chain of cascaded 2/3 cells. Each cell in the chain stretches one of its own periods once per output period when its control bit is set. Mode signals run down the chain from the last cell so that the stretch lands in the right place. Two cells follow the front stage, so every output period contains at least four front periods. That is more than the three needed to spread out three swallows, and so every ratio from 16 to 31 can be reached.

The ratio word is taken only at an output period boundary. The word in effect during a period is the one present at the input edge that ended the previous period.

Top module: `phase_switch_prescaler`

## Requirements
- R1: While `rst_n` is low, `div_out` and `pre_out` are both low.
- R2: The number of input cycles between successive rising edges of `div_out` equals 16 + `ratio_sel`, read as an unsigned 4-bit value, for every value 0 to 15.
- R3: `ratio_sel` is sampled only at the input edge that closes an output period. A change made in the middle of a period leaves that period's length unchanged, and the new value sets the length of the next full period.
- R4: Within one output period, exactly `ratio_sel[1:0]` of the front-stage (`pre_out`) periods last 5 input cycles. Every other front-stage period lasts 4 input cycles.
- R5: The number of front-stage periods in one output period is 4 + `ratio_sel[2]` + 2·`ratio_sel[3]`.
- R6: The phase selection changes only in the cycle after a rising edge of the selected phase. Each change advances it by exactly one step, and the step after the fourth phase returns to the first.
- R7: `pre_out` is free of glitches. Every low interval lasts exactly 2 input cycles, and every high interval lasts 2 or 3 input cycles.
- R8: `div_out` is a single-cycle pulse, asserted once per output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 4 | Ratio word: division ratio = 16 + value |
| pre_out | output | 1 | Multiplexed quarter-rate front-stage output |
| div_out | output | 1 | Divided output, one pulse per period |

## Verification
The bench sweeps all sixteen ratio words. For each output period it measures the period length, the number of front-stage periods in it, and how many of those were stretched to 5 cycles.

- A selection that stepped twice in one front period, or stepped at the wrong moment, would show up as a 6-cycle front period or as a short or long pulse on `pre_out`.
- A wrong mode chain between the 2/3 cells would give the right number of front periods under some control words but not others, which leaves gaps or duplicates in the ratio range.
- Each ratio change is made both at the start and in the middle of a period. A design that sampled the word at any time other than the period boundary would give a mid-period change a length that is neither the old ratio nor the new one.

// File: rtl/divp_pkg.sv
package divp_pkg;
  localparam int QUAD_PHASES = 4;
  localparam int QIDX_W      = 2;
  typedef logic [QIDX_W-1:0] quad_idx_t;
  typedef logic [QUAD_PHASES-1:0] quad_vec_t;
endpackage

// File: rtl/quad_phase_gen.sv
module quad_phase_gen
  import divp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  output quad_vec_t phases
);
  // Two-flop twisted ring: states 00 -> 01 -> 11 -> 10, period 4.
  logic [1:0] ring_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ring_q <= 2'b00;
    else        ring_q <= {ring_q[0], ~ring_q[1]};
  end

  // Each successive phase lags the previous by one input cycle.
  assign phases = {~ring_q[1], ~ring_q[0], ring_q[1], ring_q[0]};
endmodule

// File: rtl/phase_swallow.sv
module phase_swallow
  import divp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  quad_vec_t phases,
  input  logic      wrap,
  input  logic [1:0] swallow_new,
  output logic      tick,
  output logic      pre_out,
  output quad_idx_t sel
);
  logic       mux_q;
  logic [1:0] left_q;
  logic       step;

  assign pre_out = phases[sel];
  assign tick    = pre_out & ~mux_q;

  // Step on the selected phase's rising edge; at a period boundary the
  // fresh swallow count applies to the front period that starts there.
  always_comb begin
    if (!tick)     step = 1'b0;
    else if (wrap) step = (swallow_new != 2'd0);
    else           step = (left_q != 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_q  <= 1'b0;
      left_q <= 2'd0;
      sel    <= '0;
    end else begin
      mux_q <= pre_out;
      if (tick) begin
        if (wrap)
          left_q <= (swallow_new == 2'd0) ? 2'd0 : swallow_new - 2'd1;
        else if (left_q != 2'd0)
          left_q <= left_q - 2'd1;
      end
      if (step) sel <= sel + 2'd1;
    end
  end
endmodule

// File: rtl/dual_mod_cell.sv
module dual_mod_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic con,
  input  logic mod_in,
  output logic tick_out,
  output logic mod_out
);
  logic [1:0] cnt_q;
  logic       last;

  // Three input ticks for this output only when both stretch and mode are set.
  assign last     = (cnt_q == ((con & mod_in) ? 2'd2 : 2'd1));
  assign tick_out = tick_in & last;
  assign mod_out  = mod_in & last;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= 2'd0;
    else if (tick_in) cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
  end
endmodule

// File: rtl/phase_switch_prescaler.sv
module phase_switch_prescaler
  import divp_pkg::*;
#(
  parameter int NCELL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL+1:0] ratio_sel,
  output logic             pre_out,
  output logic             div_out
);
  localparam int RW = NCELL + 2;

  quad_vec_t       phases;
  quad_idx_t       sel;
  logic            tick;
  logic            wrap;
  logic [RW-1:0]   ratio_q;
  logic [NCELL:0]  tk;
  logic [NCELL:0]  md;

  quad_phase_gen u_qpg (
    .clk    (clk),
    .rst_n  (rst_n),
    .phases (phases)
  );

  phase_swallow u_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .phases      (phases),
    .wrap        (wrap),
    .swallow_new (ratio_sel[1:0]),
    .tick        (tick),
    .pre_out     (pre_out),
    .sel         (sel)
  );

  assign tk[0]     = tick;
  assign md[NCELL] = 1'b1;

  generate
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
      dual_mod_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tk[i]),
        .con      (ratio_q[i+2]),
        .mod_in   (md[i+1]),
        .tick_out (tk[i+1]),
        .mod_out  (md[i])
      );
    end
  endgenerate

  assign wrap = tk[NCELL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= '0;
      div_out <= 1'b0;
    end else begin
      if (wrap) ratio_q <= ratio_sel;
      div_out <= wrap;
    end
  end
endmodule

// File: rtl/phase_switch_prescaler_chk.sv
module phase_switch_prescaler_chk #(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pre_out,
  input logic          div_out,
  input logic          tick,
  input logic          wrap,
  input logic [1:0]    sel,
  input logic [RW-1:0] ratio_q
);
  AST_SEL_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> (sel == $past(sel) + 2'd1)); // R6
  AST_SEL_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> $past(tick)); // R6
  AST_PRE_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_out) |=> pre_out); // R7
  AST_PRE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pre_out) |=> !pre_out); // R7
  AST_DIV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out); // R8
  AST_WRAP_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> tick); // R5
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $past(wrap)); // R3
endmodule

bind phase_switch_prescaler phase_switch_prescaler_chk #(.RW(NCELL + 2)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pre_out (pre_out),
  .div_out (div_out),
  .tick    (tick),
  .wrap    (wrap),
  .sel     (sel),
  .ratio_q (ratio_q)
);

// File: tb/tb_phase_switch_prescaler.sv
`timescale 1ns/1ps
module tb_phase_switch_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ratio_sel = 4'd0;
  logic       pre_out;
  logic       div_out;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  phase_switch_prescaler #(.NCELL(2)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .pre_out   (pre_out),
    .div_out   (div_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures periods and front-stage intervals at falling edges.
  int cyc = 0;
  logic prev_pre = 1'b0, prev_div = 1'b0;
  int last_pre_rise = -1, last_div_rise = -1;
  int hi_run = 0, lo_run = 0, dhi_run = 0;
  int n4 = 0, n5 = 0, noth = 0;
  int p_len = 0, p_n4 = 0, p_n5 = 0, p_oth = 0;
  int rise_count = 0;
  bit pre_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (pre_out && !prev_pre) begin
        if (last_pre_rise >= 0) begin
          if (cyc - last_pre_rise == 4) n4++;
          else if (cyc - last_pre_rise == 5) n5++;
          else noth++;
        end
        last_pre_rise = cyc;
        if (pre_seen) chk(lo_run == 2, "R7 low run", lo_run, 2);
        pre_seen = 1'b1;
      end
      if (!pre_out && prev_pre && pre_seen)
        chk(hi_run == 2 || hi_run == 3, "R7 high run", hi_run, 2);
      if (!div_out && prev_div)
        chk(dhi_run == 1, "R8 pulse width", dhi_run, 1);
      if (div_out && !prev_div) begin
        p_len = (last_div_rise >= 0) ? cyc - last_div_rise : 0;
        p_n4 = n4; p_n5 = n5; p_oth = noth;
        n4 = 0; n5 = 0; noth = 0;
        last_div_rise = cyc;
        rise_count++;
      end
      hi_run  = pre_out ? ((pre_out == prev_pre) ? hi_run + 1 : 1) : 0;
      lo_run  = !pre_out ? ((pre_out == prev_pre) ? lo_run + 1 : 1) : 0;
      dhi_run = div_out ? dhi_run + 1 : 0;
      prev_pre = pre_out;
      prev_div = div_out;
    end
  end

  task automatic wait_rise();
    int seen;
    seen = rise_count;
    while (rise_count == seen) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check_period(input int v, input string tag);
    int m, s;
    m = 4 + ((v >> 2) & 1) + 2 * ((v >> 3) & 1);
    s = v & 3;
    chk(p_len == 16 + v, {tag, " R2 period"}, p_len, 16 + v);
    chk(p_n5 == s, "R4 stretched front periods", p_n5, s);
    chk(p_oth == 0, "R4 odd front periods", p_oth, 0);
    chk(p_n4 + p_n5 == m, "R5 front periods per output", p_n4 + p_n5, m);
  endtask

  initial begin
    int prev_v;
    repeat (4) @(negedge clk);
    #1;
    chk(div_out == 1'b0, "R1 div_out in reset", div_out, 0);
    chk(pre_out == 1'b0, "R1 pre_out in reset", pre_out, 0);
    rst_n = 1'b1;
    wait_rise();
    wait_rise();
    prev_v = -1;
    for (int v = 0; v < 16; v++) begin
      ratio_sel = 4'(v);
      wait_rise();
      if (prev_v >= 0) check_period(prev_v, "R3 new word after boundary");
      wait_rise();
      check_period(v, "sweep");
      repeat (7) @(negedge clk);
      #1;
      ratio_sel = 4'(v ^ 15);
      wait_rise();
      check_period(v, "R3 mid-period change ignored");
      prev_v = v ^ 15;
    end
    ratio_sel = 4'd9;
    wait_rise();
    check_period(prev_v, "R3 final word");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rise_count, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule